// File: doc/BRIEF.md
# Register Rename Translation Matrix

This block keeps the current pairing between architectural register numbers and virtual (renamed) register numbers. The pairing is stored as a two-dimensional grid of single-bit cells. Rows stand for architectural registers and columns for virtual registers. A stored 1 at row r, column c means virtual register c currently names real register r. Two set ports, one per issue slot, each present a unary row vector and a unary column vector. The cell where an accepted port's row and column cross is written in the same clock edge as the other port's cell. A per-column clear vector retires mappings.

The lookup side translates a virtual register-file port request into a real one. A column selection, given either as a unary vector or as a binary index, is gated by a request strobe. It is ANDed with each cell, and each row ORs its cells into a one-hot row output that names the real register. The block only translates names. Data movement, free-list management and decode are handled elsewhere.

Top module: `rename_matrix`

## Requirements
- R1: With `rst_n` low at a rising clock edge, every cell is cleared, and afterwards every lookup returns an all-zero row and `lk_valid` low.
- R2: A set port whose row vector and column vector each have exactly one bit set, and whose column is not cleared in that cycle, stores a 1 at the crossing cell at the next rising edge.
- R3: A set port whose row or column vector has zero bits or more than one bit set has no effect on the matrix.
- R4: Writing cell (r,c) clears every other stored cell in row r and in column c at the same edge, so the new mapping replaces older ones.
- R5: When the accepted writes of both set ports use different rows and different columns, both cells are written at the same edge.
- R6: When an accepted Set1 write shares a row or a column with a well-formed Set2 write, Set2 has no effect at all in that cycle. A Set1 that was not accepted never blocks Set2.
- R7: A bit of `clr_col` high at a rising edge empties that column. A set write targeting a cleared column is dropped entirely, including its displacement of other cells.
- R8: With `lk_req` low, `lk_row` is all zero and `lk_valid` is low, whatever the selection inputs.
- R9: With `lk_req` high and `lk_bin_mode` = 0, `lk_row` is the bitwise OR of the stored columns marked in `lk_col`, and `lk_valid` is high exactly when `lk_row` is non-zero.
- R10: With `lk_req` high and `lk_bin_mode` = 1, `lk_idx` is decoded as a column number, and `lk_row` is that column's contents. An empty column, or an index of `NUM_VIRT` or above, gives zero and `lk_valid` low. The result is always zero-or-one-hot.
- R11: Lookup outputs follow the current stored state combinationally. A set or clear presented in a cycle becomes visible only after the next rising edge.
- R12: At every point in time, each row and each column holds at most one set cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the whole matrix |
| s1_row | input | NUM_ARCH | Set port 1 unary row (architectural register) select |
| s1_col | input | NUM_VIRT | Set port 1 unary column (virtual register) select |
| s2_row | input | NUM_ARCH | Set port 2 unary row select |
| s2_col | input | NUM_VIRT | Set port 2 unary column select |
| clr_col | input | NUM_VIRT | Per-column clear vector |
| lk_req | input | 1 | Lookup request strobe, enables the column select |
| lk_bin_mode | input | 1 | 0: column given by `lk_col`; 1: column given by `lk_idx` |
| lk_col | input | NUM_VIRT | Unary lookup column selection |
| lk_idx | input | IDX_W | Binary lookup column number, IDX_W = clog2(NUM_VIRT) |
| lk_row | output | NUM_ARCH | Translated row, one-hot for a single mapped column |
| lk_valid | output | 1 | High when `lk_row` is non-zero |

## Verification
The bench builds the matrix with 4 rows and 6 columns. At that size every single-port write position can be tried and every pairing of the two set ports can be enumerated (576 combinations), so all row and column conflicts between the ports occur. The column count is not a power of two, so the 3-bit binary index also reaches the two out-of-range values 6 and 7. After every edge the whole grid is read back through both lookup modes and compared with a bench-side map derived from the requirements. A long pseudo-random phase mixes malformed selects, clears and global resets.

// File: rtl/rename_matrix_pkg.sv
// Package rename_matrix_pkg
// Shared types for the rename translation matrix.
// Assumes: nothing beyond IEEE 1800-2017.
package rename_matrix_pkg;

    // How the lookup column is presented.
    typedef enum logic {
        SEL_UNARY  = 1'b0,
        SEL_BINARY = 1'b1
    } sel_mode_e;

    // Width of a binary column index for a given column count.
    function automatic int idx_width(input int cols);
        return (cols > 1) ? $clog2(cols) : 1;
    endfunction

endpackage

// File: rtl/rm_set_arbiter.sv
// Module rm_set_arbiter
// Decides which of the two set ports is accepted this cycle.
// A port qualifies when its row and column selects are each single-bit.
// A port is then dropped when its column is being cleared. Set2 is also
// dropped when it shares a row or column with an accepted Set1.
// Assumes: purely combinational, the caller registers the result.
module rm_set_arbiter #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_VIRT = 16
) (
    input  logic [NUM_ARCH-1:0] s1_row,
    input  logic [NUM_VIRT-1:0] s1_col,
    input  logic [NUM_ARCH-1:0] s2_row,
    input  logic [NUM_VIRT-1:0] s2_col,
    input  logic [NUM_VIRT-1:0] clr_col,
    output logic                acc1,
    output logic                acc2
);

    logic form1;
    logic form2;
    logic hit_clr1;
    logic hit_clr2;
    logic clash;

    // Shape check, clear-collision check and port priority.
    always_comb begin
        form1    = $onehot(s1_row) && $onehot(s1_col);
        form2    = $onehot(s2_row) && $onehot(s2_col);
        hit_clr1 = |(s1_col & clr_col);
        hit_clr2 = |(s2_col & clr_col);
        acc1     = form1 && !hit_clr1;
        clash    = (|(s1_row & s2_row)) || (|(s1_col & s2_col));
        acc2     = form2 && !hit_clr2 && !(acc1 && clash);
    end

endmodule

// File: rtl/rm_cell_array.sv
// Module rm_cell_array
// The storage grid: one flop per (row, column) cross-point.
// Precedence per cell: global reset, then column clear, then a write,
// then displacement by a write elsewhere in the same row or column, then hold.
// Assumes: acc1/acc2 only ever point at disjoint rows and columns, and
// each accepted port's vectors are single-bit (ensured by rm_set_arbiter).
module rm_cell_array #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_VIRT = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc1,
    input  logic                               acc2,
    input  logic [NUM_ARCH-1:0]                s1_row,
    input  logic [NUM_VIRT-1:0]                s1_col,
    input  logic [NUM_ARCH-1:0]                s2_row,
    input  logic [NUM_VIRT-1:0]                s2_col,
    input  logic [NUM_VIRT-1:0]                clr_col,
    output logic [NUM_ARCH-1:0][NUM_VIRT-1:0]  cells
);

    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_row
        for (genvar c = 0; c < NUM_VIRT; c++) begin : g_col
            logic wr_hit;
            logic disp_hit;

            // Decode whether this cell is written or displaced.
            always_comb begin
                wr_hit   = (acc1 && s1_row[r] && s1_col[c]) ||
                           (acc2 && s2_row[r] && s2_col[c]);
                disp_hit = (acc1 && (s1_row[r] || s1_col[c])) ||
                           (acc2 && (s2_row[r] || s2_col[c]));
            end

            // Cell register with the fixed precedence above.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cells[r][c] <= 1'b0;
                end else if (clr_col[c]) begin
                    cells[r][c] <= 1'b0;
                end else if (wr_hit) begin
                    cells[r][c] <= 1'b1;
                end else if (disp_hit) begin
                    cells[r][c] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rm_col_select.sv
// Module rm_col_select
// Forms the request-gated column select for a lookup. The binary index is
// decoded behind the enable (request and binary mode), so that a change
// of the index never opens a column while no lookup is requested.
// Assumes: combinational; an index at or above NUM_VIRT selects nothing.
module rm_col_select #(
    parameter int NUM_VIRT = 16,
    parameter int IDX_W    = 4
) (
    input  logic                                lk_req,
    input  rename_matrix_pkg::sel_mode_e        mode,
    input  logic [NUM_VIRT-1:0]                 lk_col,
    input  logic [IDX_W-1:0]                    lk_idx,
    output logic [NUM_VIRT-1:0]                 sel
);

    import rename_matrix_pkg::*;

    logic                dec_en;
    logic                uny_en;
    logic [NUM_VIRT-1:0] dec_sel;

    // Enables for the two selection paths.
    always_comb begin
        dec_en = lk_req && (mode == SEL_BINARY);
        uny_en = lk_req && (mode == SEL_UNARY);
    end

    for (genvar c = 0; c < NUM_VIRT; c++) begin : g_dec
        // One decoder output per column, held low unless enabled.
        always_comb begin
            dec_sel[c] = dec_en && (int'(lk_idx) == c);
        end
    end

    // Merge the two paths; only one enable is ever high.
    always_comb begin
        sel = dec_sel | (lk_col & {NUM_VIRT{uny_en}});
    end

endmodule

// File: rtl/rm_row_reduce.sv
// Module rm_row_reduce
// AND-OR reduction: each row output is the OR over columns of
// (stored bit AND column select).
// Assumes: combinational; cells obey the one-per-row/column rule.
module rm_row_reduce #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_VIRT = 16
) (
    input  logic [NUM_ARCH-1:0][NUM_VIRT-1:0] cells,
    input  logic [NUM_VIRT-1:0]               sel,
    output logic [NUM_ARCH-1:0]               row,
    output logic                              valid
);

    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_or
        // Wide OR of the gated cells in this row.
        always_comb begin
            row[r] = |(cells[r] & sel);
        end
    end

    // Any row lit means the translation hit.
    always_comb begin
        valid = |row;
    end

endmodule

// File: rtl/rename_matrix.sv
// Module rename_matrix
// Top of the rename translation matrix. Two set ports write architectural
// to virtual mappings into a bit grid. A per-column clear retires them,
// and a gated lookup turns a virtual column into a one-hot real row.
// Assumes: synchronous active-low reset; set and clear act at the rising
// edge; lookup is combinational from the stored grid.
module rename_matrix #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_VIRT = 16,
    localparam int IDX_W   = rename_matrix_pkg::idx_width(NUM_VIRT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ARCH-1:0] s1_row,
    input  logic [NUM_VIRT-1:0] s1_col,
    input  logic [NUM_ARCH-1:0] s2_row,
    input  logic [NUM_VIRT-1:0] s2_col,
    input  logic [NUM_VIRT-1:0] clr_col,
    input  logic                lk_req,
    input  logic                lk_bin_mode,
    input  logic [NUM_VIRT-1:0] lk_col,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic [NUM_ARCH-1:0] lk_row,
    output logic                lk_valid
);

    import rename_matrix_pkg::*;

    logic                              acc1;
    logic                              acc2;
    logic [NUM_ARCH-1:0][NUM_VIRT-1:0] cells;
    logic [NUM_VIRT-1:0]               sel;
    sel_mode_e                         mode;

    // Interpret the mode pin as the shared enum.
    always_comb begin
        mode = sel_mode_e'(lk_bin_mode);
    end

    rm_set_arbiter #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_VIRT (NUM_VIRT)
    ) u_arb (
        .s1_row  (s1_row),
        .s1_col  (s1_col),
        .s2_row  (s2_row),
        .s2_col  (s2_col),
        .clr_col (clr_col),
        .acc1    (acc1),
        .acc2    (acc2)
    );

    rm_cell_array #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_VIRT (NUM_VIRT)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc1    (acc1),
        .acc2    (acc2),
        .s1_row  (s1_row),
        .s1_col  (s1_col),
        .s2_row  (s2_row),
        .s2_col  (s2_col),
        .clr_col (clr_col),
        .cells   (cells)
    );

    rm_col_select #(
        .NUM_VIRT (NUM_VIRT),
        .IDX_W    (IDX_W)
    ) u_sel (
        .lk_req (lk_req),
        .mode   (mode),
        .lk_col (lk_col),
        .lk_idx (lk_idx),
        .sel    (sel)
    );

    rm_row_reduce #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_VIRT (NUM_VIRT)
    ) u_red (
        .cells (cells),
        .sel   (sel),
        .row   (lk_row),
        .valid (lk_valid)
    );

endmodule

// File: rtl/rename_matrix_chk.sv
// Module rename_matrix_chk
// Property checker for rename_matrix, attached by the bind below.
// Assumes: it sees the stored grid of the top through the bind port.
module rename_matrix_chk #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_VIRT = 16
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_ARCH-1:0]               s1_row,
    input logic [NUM_VIRT-1:0]               s1_col,
    input logic [NUM_ARCH-1:0]               s2_row,
    input logic [NUM_VIRT-1:0]               s2_col,
    input logic [NUM_VIRT-1:0]               clr_col,
    input logic                              lk_req,
    input logic                              lk_bin_mode,
    input logic [NUM_ARCH-1:0]               lk_row,
    input logic                              lk_valid,
    input logic [NUM_ARCH-1:0][NUM_VIRT-1:0] cells
);

    logic [NUM_VIRT-1:0] col_occ;

    // Column occupancy derived from the grid.
    always_comb begin
        col_occ = '0;
        for (int r = 0; r < NUM_ARCH; r++) begin
            col_occ = col_occ | cells[r];
        end
    end

    // Global reset empties the grid at the next edge.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (cells == '0));

    // With no well-formed set and no clear, the grid holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!($onehot(s1_row) && $onehot(s1_col)) &&
         !($onehot(s2_row) && $onehot(s2_col)) && clr_col == '0)
        |=> $stable(cells));

    // Cleared columns are empty afterwards.
    assert_col_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_col != '0) |=> ((col_occ & $past(clr_col)) == '0));

    // No request, no translation.
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (lk_row == '0 && !lk_valid));

    // Binary lookups are never multi-hot.
    assert_bin_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_bin_mode) |-> $onehot0(lk_row));

    for (genvar r = 0; r < NUM_ARCH; r++) begin : g_r
        // At most one cell per row.
        assert_row_unique_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(cells[r]));
        for (genvar c = 0; c < NUM_VIRT; c++) begin : g_c
            // A well-formed, unblocked Set1 lands in its cell.
            assert_set1_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (s1_row[r] && s1_col[c] && $onehot(s1_row) && $onehot(s1_col) &&
                 !clr_col[c]) |=> cells[r][c]);
        end
    end

    for (genvar c = 0; c < NUM_VIRT; c++) begin : g_cu
        logic [NUM_ARCH-1:0] colv;
        // Gather one column of the grid.
        always_comb begin
            for (int r = 0; r < NUM_ARCH; r++) colv[r] = cells[r][c];
        end
        // At most one cell per column.
        assert_col_unique_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(colv));
    end

endmodule

bind rename_matrix rename_matrix_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_VIRT (NUM_VIRT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s1_row      (s1_row),
    .s1_col      (s1_col),
    .s2_row      (s2_row),
    .s2_col      (s2_col),
    .clr_col     (clr_col),
    .lk_req      (lk_req),
    .lk_bin_mode (lk_bin_mode),
    .lk_row      (lk_row),
    .lk_valid    (lk_valid),
    .cells       (cells)
);

// File: tb/rename_matrix_tb.sv
`timescale 1ns/1ps
module rename_matrix_tb;

    localparam int NA         = 4;
    localparam int NV         = 6;
    localparam int IW         = 3;
    localparam int CLK_PERIOD = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NA-1:0] s1_row, s2_row;
    logic [NV-1:0] s1_col, s2_col, clr_col;
    logic          lk_req, lk_bin_mode;
    logic [NV-1:0] lk_col;
    logic [IW-1:0] lk_idx;
    logic [NA-1:0] lk_row;
    logic          lk_valid;

    logic [NA-1:0][NV-1:0] m;
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lf = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_matrix #(.NUM_ARCH(NA), .NUM_VIRT(NV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .s1_row(s1_row), .s1_col(s1_col), .s2_row(s2_row), .s2_col(s2_col),
        .clr_col(clr_col), .lk_req(lk_req), .lk_bin_mode(lk_bin_mode),
        .lk_col(lk_col), .lk_idx(lk_idx), .lk_row(lk_row), .lk_valid(lk_valid)
    );

    function automatic logic [NA-1:0] expect_cols(input logic [NV-1:0] cs);
        logic [NA-1:0] e = '0;
        for (int r = 0; r < NA; r++)
            for (int c = 0; c < NV; c++)
                if (cs[c] && m[r][c]) e[r] = 1'b1;
        return e;
    endfunction

    task automatic check(input string tag, input logic [NA-1:0] exp);
        n_chk++;
        if (lk_row !== exp || lk_valid !== (|exp)) begin
            n_bad++;
            $display("FAIL %s: row=%b valid=%b expected row=%b valid=%b",
                     tag, lk_row, lk_valid, exp, |exp);
        end
    endtask

    // Read the whole grid back through both lookup modes.
    task automatic sweep(input string tag);
        lk_req = 1'b1;
        lk_bin_mode = 1'b0;
        for (int c = 0; c < NV; c++) begin
            lk_col = NV'(1) << c;
            #1 check({tag, " R9 R12 unary"}, expect_cols(lk_col));
        end
        lk_col = 6'b101101;                       // multi-column OR (R9)
        #1 check({tag, " R9 multi"}, expect_cols(lk_col));
        lk_bin_mode = 1'b1;
        lk_col = '0;
        for (int i = 0; i < 8; i++) begin
            lk_idx = IW'(i);
            #1 check({tag, " R10 binary"},
                     (i < NV) ? expect_cols(NV'(1) << i) : '0);
        end
        lk_req = 1'b0;
        lk_col = '1;
        lk_idx = '0;
        #1 check({tag, " R8 idle"}, '0);
        lk_col = '0;
    endtask

    // Bench-side map update, derived from R2..R7.
    task automatic model_step();
        logic f1, f2, a1, a2;
        logic [NA-1:0][NV-1:0] nx;
        f1 = ($countones(s1_row) == 1) && ($countones(s1_col) == 1);
        f2 = ($countones(s2_row) == 1) && ($countones(s2_col) == 1);
        a1 = f1 && ((s1_col & clr_col) == '0);
        a2 = f2 && ((s2_col & clr_col) == '0) &&
             !(a1 && (((s1_row & s2_row) != '0) || ((s1_col & s2_col) != '0)));
        nx = m;
        for (int r = 0; r < NA; r++)
            for (int c = 0; c < NV; c++) begin
                if ((a1 && (s1_row[r] || s1_col[c])) || (a2 && (s2_row[r] || s2_col[c])))
                    nx[r][c] = 1'b0;
                if ((a1 && s1_row[r] && s1_col[c]) || (a2 && s2_row[r] && s2_col[c]))
                    nx[r][c] = 1'b1;
                if (clr_col[c]) nx[r][c] = 1'b0;
            end
        m = nx;
    endtask

    task automatic step(input logic [NA-1:0] r1, input logic [NV-1:0] c1,
                        input logic [NA-1:0] r2, input logic [NV-1:0] c2,
                        input logic [NV-1:0] cl, input string tag);
        s1_row = r1; s1_col = c1; s2_row = r2; s2_col = c2; clr_col = cl;
        lk_req = 1'b1; lk_bin_mode = 1'b0; lk_col = c1 | c2 | cl;
        #1 check({tag, " R11 pre-edge"}, expect_cols(lk_col));
        @(posedge clk);
        model_step();
        #1;
        s1_row = '0; s1_col = '0; s2_row = '0; s2_col = '0; clr_col = '0;
        sweep(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        s1_row = 4'b0001; s1_col = 6'b000001; s2_row = 4'b0010; s2_col = 6'b000010;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        s1_row = '0; s1_col = '0; s2_row = '0; s2_col = '0;
        m = '0;
        sweep(tag);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        logic [31:0] x = v;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        s1_row = '0; s1_col = '0; s2_row = '0; s2_col = '0; clr_col = '0;
        lk_req = 1'b0; lk_bin_mode = 1'b0; lk_col = '0; lk_idx = '0;
        m = '0;
        #3;
        do_reset("R1 power-on");

        // Every single-port write position, both ports (R2, R4).
        for (int r = 0; r < NA; r++)
            for (int c = 0; c < NV; c++)
                step(NA'(1) << r, NV'(1) << c, '0, '0, '0, "R2 R4 set1");
        for (int r = 0; r < NA; r++)
            for (int c = 0; c < NV; c++)
                step('0, '0, NA'(1) << r, NV'(1) << c, '0, "R2 R4 set2");

        // Each column cleared in turn (R7).
        for (int c = 0; c < NV; c++)
            step('0, '0, '0, '0, NV'(1) << c, "R7 clear");

        // Every pairing of the two ports (R5, R6).
        for (int r1 = 0; r1 < NA; r1++)
            for (int c1 = 0; c1 < NV; c1++)
                for (int r2 = 0; r2 < NA; r2++)
                    for (int c2 = 0; c2 < NV; c2++)
                        step(NA'(1) << r1, NV'(1) << c1, NA'(1) << r2, NV'(1) << c2,
                             '0, "R5 R6 pair");

        // Malformed selects are ignored (R3).
        step(4'b0011, 6'b000100, '0, '0, '0, "R3 multi-row");
        step(4'b0100, 6'b011000, '0, '0, '0, "R3 multi-col");
        step('0, 6'b000001, 4'b1000, '0, '0, "R3 empty");
        // Malformed Set1 does not block Set2 (R6).
        step(4'b0110, 6'b000001, 4'b0010, 6'b000001, '0, "R6 bad set1");

        // Clear beats a set on the same column; other port still works (R7).
        step(4'b0001, 6'b000010, 4'b0100, 6'b100000, 6'b000010, "R7 clear wins");
        step(4'b1000, 6'b000100, '0, '0, 6'b000100, "R7 dropped no displace");

        // Mid-run global reset with a loaded grid (R1).
        step(4'b0001, 6'b000001, 4'b0010, 6'b000010, '0, "R1 load");
        do_reset("R1 mid-run");

        // Pseudo-random traffic (R12).
        for (int k = 0; k < 2000; k++) begin
            logic [NA-1:0] a; logic [NV-1:0] b; logic [NA-1:0] d; logic [NV-1:0] e;
            logic [NV-1:0] cl;
            lf = nxt(lf);
            a = (lf[2:0] == 0) ? lf[11:8] : NA'(1) << (lf[15:12] % NA);
            b = (lf[5:3] == 0) ? lf[21:16] : NV'(1) << (lf[27:24] % NV);
            lf = nxt(lf);
            d = (lf[2:0] == 0) ? lf[11:8] : NA'(1) << (lf[15:12] % NA);
            e = (lf[5:3] == 0) ? lf[21:16] : NV'(1) << (lf[27:24] % NV);
            cl = (lf[30:28] == 0) ? NV'(1) << (lf[7:6] % NV) : '0;
            if (lf[31:24] == 8'hA5) do_reset("R1 random");
            else step(a, b, d, e, cl, "R12 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule